// File: doc/BRIEF.md
# Framed Serial I/Q Output Port

This block turns complex baseband sample pairs into a framed serial stream on a single data line. Each pair holds an in-phase (I) word and a quadrature (Q) word. The port drives four lines besides the data: a bit clock derived from the system clock, a frame-sync line, a data-ready line and a sticky overflow flag. A transfer always sends the I word first and then the Q word, MSB first, one bit per serial clock period. The word length is chosen from four fixed-point sizes.

The framing has two modes. Unpacked framing pulses frame sync at the first bit of every word. Packed framing pulses it only at the first bit of the I word, so one pulse covers the whole double word. The active level of the bit clock, the frame sync and the ready line can each be inverted with its own polarity input.

A pair that arrives while a transfer is running waits in a one-deep holding stage. When a transfer ends and that stage holds a pair, the next transfer starts with no idle gap. A pair that arrives while the stage is full and is not being emptied in that cycle is dropped, and the overflow flag is raised.

Top module: `ser_iq_out`

## Requirements
- R1: While reset is asserted and just after it, the port is idle: `sclk` equals `sclk_pol`, `sfs` equals `sync_pol`, `rdy` equals `rdy_pol`, `sdata` is 0 and `ovf` is 0.
- R2: `wsel` picks the word length W: code 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bits. A transfer sends the low W bits of `in_i` and then the low W bits of `in_q`, MSB first, one bit per serial clock period, for 2W bits in all.
- R3: With `pack_mode`=0, frame sync is active during the first bit period of the I word and again during the first bit period of the Q word.
- R4: With `pack_mode`=1, frame sync is active only during the first bit period of the I word. It stays inactive for the rest of the transfer.
- R5: Frame sync is active for exactly one serial clock period per pulse. Its active level is high when `sync_pol`=0 and low when `sync_pol`=1, and it is never active outside a transfer.
- R6: One serial bit period lasts 2*(`div_half`+1) system clocks. During the first half the uninverted bit clock is low and during the second half it is high. `sdata` changes only at the start of a bit period. `sclk_pol`=1 inverts the bit clock. Between transfers the bit clock rests at its inactive level, which equals `sclk_pol`.
- R7: The ready line is active for the whole I word of each transfer, so its leading edge marks the first bit of a new transfer. Its active level is high when `rdy_pol`=0 and low when `rdy_pol`=1.
- R8: A pair presented with `in_valid` for one cycle while the port is busy is held and sent next. If it is held when a transfer ends, the next transfer's first bit follows the previous transfer's last bit with no idle cycle.
- R9: A pair that arrives while the holding stage is full and is not being emptied in that cycle is dropped and never sent. `ovf` then goes to 1 and stays 1 until reset.
- R10: `wsel`, `pack_mode` and `div_half` are captured when a transfer starts. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe presenting a new I/Q pair |
| in_i | input | DW | In-phase word, right-aligned |
| in_q | input | DW | Quadrature word, right-aligned |
| wsel | input | 2 | Word length code (0:8, 1:16, 2:24, 3:32 bits) |
| pack_mode | input | 1 | 1 = one sync pulse per pair, 0 = one per word |
| div_half | input | DIV_W | Half bit period in system clocks, minus one |
| sclk_pol | input | 1 | Inverts the serial bit clock |
| sync_pol | input | 1 | Makes frame sync active low |
| rdy_pol | input | 1 | Makes the ready line active low |
| sclk | output | 1 | Serial bit clock |
| sfs | output | 1 | Frame sync |
| sdata | output | 1 | Serial data, MSB first |
| rdy | output | 1 | Ready, active over the I word |
| ovf | output | 1 | Sticky overflow of the holding stage |

## Verification
The bench sends pairs at all four word lengths and three divider settings, in both framing modes and with every polarity bit set. It goes after the corner cases where a wrong design would still look plausible. A pair arriving exactly in the cycle the holding stage is drained must be kept, not flagged; a design that checks fullness before the drain would raise a false overflow. Back-to-back transfers must leave no idle cycle between them, which a design with a separate load state would insert. A mid-transfer change of width, mode or divider must not disturb the running transfer, and a design sampling those inputs live would corrupt the bit count or reshape the clock. In packed mode a sync pulse leaking onto the Q word would show the framing modes swapped.

// File: rtl/ser_iq_pkg.sv
package ser_iq_pkg;

    // Word length in bits for a 2-bit size code: 0->8, 1->16, 2->24, 3->32.
    function automatic logic [6:0] word_bits(input logic [1:0] code);
        word_bits = {2'b00, code, 3'b000} + 7'd8;
    endfunction

    // Uninverted framing lines before polarity is applied.
    typedef struct packed {
        logic clk_hi;
        logic sync;
        logic ready;
    } raw_lines_t;

endpackage

// File: rtl/ser_pair_buf.sv
module ser_pair_buf #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] hold_i,
    output logic [DW-1:0] hold_q,
    output logic          ovf
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] i;
        logic [DW-1:0] q;
        logic          ovf;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            // The slot is free, or it is being drained in this very cycle.
            if (!st_q.full || take) begin
                st_d.full = 1'b1;
                st_d.i    = in_i;
                st_d.q    = in_q;
            end else begin
                st_d.ovf  = 1'b1;
            end
        end else if (take) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full   = st_q.full;
    assign hold_i = st_q.i;
    assign hold_q = st_q.q;
    assign ovf    = st_q.ovf;

endmodule

// File: rtl/ser_bitclk_gen.sv
module ser_bitclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             half,
    output logic             bit_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
        logic             half;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    at_lim;

    assign at_lim = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
            st_d.lim  = div_in;
        end else if (run) begin
            if (at_lim) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half     = st_q.half;
    assign bit_tick = run && st_q.half && at_lim;

endmodule

// File: rtl/ser_frame_shifter.sv
module ser_frame_shifter
    import ser_iq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] ld_i,
    input  logic [DW-1:0] ld_q,
    input  logic [1:0]    wsel,
    input  logic          pack_in,
    input  logic          bit_tick,
    input  logic          half,
    output logic          active,
    output logic          last,
    output logic          pk,
    output logic          sd_raw,
    output raw_lines_t    lines
);

    localparam int SRW = 2 * DW;
    localparam int CW  = $clog2(SRW + 1);

    typedef struct packed {
        logic           active;
        logic           pk;
        logic [CW-1:0]  w;
        logic [CW-1:0]  cnt;
        logic [SRW-1:0] sr;
    } sh_st_t;

    sh_st_t         st_d, st_q;
    logic [CW-1:0]  wb_ld;
    logic [CW-1:0]  last_idx;
    logic [SRW-1:0] ext_i, ext_q, joined;

    assign wb_ld    = CW'(word_bits(wsel));
    assign last_idx = (st_q.w << 1) - 1'b1;
    assign last     = st_q.active && bit_tick && (st_q.cnt == last_idx);

    // Keep the low W bits of each word, put I above Q, then left-align.
    always_comb begin
        ext_i = '0;
        ext_q = '0;
        for (int b = 0; b < DW; b++) begin
            ext_i[b] = ld_i[b] & (b < int'(wb_ld));
            ext_q[b] = ld_q[b] & (b < int'(wb_ld));
        end
        joined = ((ext_i << wb_ld) | ext_q) << (SRW - 2 * int'(wb_ld));
    end

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.active = 1'b1;
            st_d.pk     = pack_in;
            st_d.w      = wb_ld;
            st_d.cnt    = '0;
            st_d.sr     = joined;
        end else if (last) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.sr     = '0;
        end else if (st_q.active && bit_tick) begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.sr     = st_q.sr << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active       = st_q.active;
    assign pk           = st_q.pk;
    assign sd_raw       = st_q.sr[SRW-1];
    assign lines.clk_hi = st_q.active && half;
    assign lines.ready  = st_q.active && (st_q.cnt < st_q.w);
    assign lines.sync   = st_q.active &&
                          ((st_q.cnt == '0) || (!st_q.pk && (st_q.cnt == st_q.w)));

endmodule

// File: rtl/ser_iq_out.sv
module ser_iq_out
    import ser_iq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_i,
    input  logic [DW-1:0]    in_q,
    input  logic [1:0]       wsel,
    input  logic             pack_mode,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sclk_pol,
    input  logic             sync_pol,
    input  logic             rdy_pol,
    output logic             sclk,
    output logic             sfs,
    output logic             sdata,
    output logic             rdy,
    output logic             ovf
);

    logic          full_w, take_w, busy_w, last_w, pk_w;
    logic          half_w, tick_w, sd_w;
    logic [DW-1:0] hold_i_w, hold_q_w;
    raw_lines_t    lines_w;

    // A held pair starts when idle or right on the last bit tick.
    assign take_w = full_w && (!busy_w || last_w);

    ser_pair_buf #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .take     (take_w),
        .full     (full_w),
        .hold_i   (hold_i_w),
        .hold_q   (hold_q_w),
        .ovf      (ovf)
    );

    ser_bitclk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take_w),
        .run      (busy_w),
        .div_in   (div_half),
        .half     (half_w),
        .bit_tick (tick_w)
    );

    ser_frame_shifter #(.DW(DW)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_w),
        .ld_i     (hold_i_w),
        .ld_q     (hold_q_w),
        .wsel     (wsel),
        .pack_in  (pack_mode),
        .bit_tick (tick_w),
        .half     (half_w),
        .active   (busy_w),
        .last     (last_w),
        .pk       (pk_w),
        .sd_raw   (sd_w),
        .lines    (lines_w)
    );

    assign sclk  = lines_w.clk_hi ^ sclk_pol;
    assign sfs   = lines_w.sync   ^ sync_pol;
    assign rdy   = lines_w.ready  ^ rdy_pol;
    assign sdata = sd_w;

endmodule

// File: rtl/ser_iq_out_chk.sv
module ser_iq_out_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic pk,
    input logic sclk,
    input logic sfs,
    input logic sdata,
    input logic rdy,
    input logic ovf,
    input logic sclk_pol,
    input logic sync_pol,
    input logic rdy_pol
);

    // R9: overflow is sticky until reset
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R6: bit clock rests at its inactive level between transfers
    a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == sclk_pol));

    // R6: data holds while the bit clock is in its high half
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (sclk ^ sclk_pol)) |-> $stable(sdata));

    // R5: frame sync never active outside a transfer
    a_r5_sync_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (sfs ^ sync_pol) |-> busy);

    // R7: ready never active outside a transfer
    a_r7_rdy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy ^ rdy_pol) |-> busy);

    // R4: packed framing keeps sync off during the Q word
    a_r4_no_q_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pk && !(rdy ^ rdy_pol)) |-> !(sfs ^ sync_pol));

    // R3: unpacked framing marks the first Q bit with sync
    a_r3_q_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pk && $fell(rdy ^ rdy_pol)) |-> (sfs ^ sync_pol));

endmodule

bind ser_iq_out ser_iq_out_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .pk       (pk_w),
    .sclk     (sclk),
    .sfs      (sfs),
    .sdata    (sdata),
    .rdy      (rdy),
    .ovf      (ovf),
    .sclk_pol (sclk_pol),
    .sync_pol (sync_pol),
    .rdy_pol  (rdy_pol)
);

// File: tb/tb_ser_iq_out.sv
module tb_ser_iq_out;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_i = '0, in_q = '0;
    logic [1:0]  wsel = 2'd0;
    logic        pack_mode = 1'b0;
    logic [7:0]  div_half = 8'd0;
    logic        sclk_pol = 1'b0, sync_pol = 1'b0, rdy_pol = 1'b0;
    logic        sclk, sfs, sdata, rdy, ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    always #(CLK_P/2) clk = ~clk;

    ser_iq_out dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .wsel(wsel), .pack_mode(pack_mode), .div_half(div_half),
        .sclk_pol(sclk_pol), .sync_pol(sync_pol), .rdy_pol(rdy_pol),
        .sclk(sclk), .sfs(sfs), .sdata(sdata), .rdy(rdy), .ovf(ovf)
    );

    // ---------------- behavioural reference ----------------
    logic        m_busy = 0, m_full = 0, m_ovf = 0, m_pk = 0;
    int          m_el = 0, m_w = 8, m_div = 0;
    logic [31:0] m_i = '0, m_q = '0, b_i = '0, b_q = '0;

    function automatic int total_cycles();
        return 2 * m_w * 2 * (m_div + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_ovf = 0; m_el = 0;
        end else begin
            bit lst, tk;
            lst = m_busy && (m_el == total_cycles() - 1);
            tk  = m_full && (!m_busy || lst);
            if (tk) begin
                m_busy = 1; m_el = 0; m_i = b_i; m_q = b_q;
                m_w = (int'(wsel) + 1) * 8; m_pk = pack_mode; m_div = int'(div_half);
            end else if (lst) begin
                m_busy = 0; m_el = 0;
            end else if (m_busy) begin
                m_el++;
            end
            if (in_valid) begin
                if (!m_full || tk) begin
                    m_full = 1; b_i = in_i; b_q = in_q;
                end else begin
                    m_ovf = 1;
                end
            end else if (tk) begin
                m_full = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (phase %s) act=%0h exp=%0h", tag, phase, act, exp);
        end
    endtask

    // ---------------- per-cycle comparison ----------------
    int  cyc = 0, sfs_rises = 0, rdy_rises = 0, rdy_t0 = 0, rdy_t1 = 0;
    bit  p_sfs = 0, p_rdy = 0;

    always begin
        @(posedge clk);
        #(CLK_P/4);
        cyc++;
        if (rst_n && !done) begin
            bit e_ck, e_fs, e_rd, e_sd;
            e_ck = 0; e_fs = 0; e_rd = 0; e_sd = 0;
            if (m_busy) begin
                int bp, bt, wd, pos;
                bp  = 2 * (m_div + 1);
                bt  = m_el / bp;
                e_ck = (m_el % bp) > m_div;
                wd  = bt / m_w;
                pos = bt % m_w;
                e_sd = (wd == 0) ? m_i[m_w-1-pos] : m_q[m_w-1-pos];
                e_fs = (pos == 0) && (wd == 0 || !m_pk);
                e_rd = (wd == 0);
            end
            chk(sdata == e_sd, "R2 sdata", sdata, e_sd);
            chk(sclk == (e_ck ^ sclk_pol), "R6 sclk", sclk, e_ck ^ sclk_pol);
            chk(sfs == (e_fs ^ sync_pol), "R5 sfs", sfs, e_fs ^ sync_pol);
            chk(rdy == (e_rd ^ rdy_pol), "R7 rdy", rdy, e_rd ^ rdy_pol);
            chk(ovf == m_ovf, "R9 ovf", ovf, m_ovf);
            if ((sfs ^ sync_pol) && !p_sfs) sfs_rises++;
            if ((rdy ^ rdy_pol) && !p_rdy) begin
                rdy_rises++; rdy_t0 = rdy_t1; rdy_t1 = cyc;
            end
            p_sfs = sfs ^ sync_pol;
            p_rdy = rdy ^ rdy_pol;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1; in_i = a; in_q = b;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy || m_full) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        int s0, r0;
        // R1: reset state at both polarity settings
        repeat (2) @(negedge clk);
        chk(sclk == 0 && sfs == 0 && rdy == 0 && sdata == 0 && ovf == 0,
            "R1 reset idle", {sclk, sfs, rdy, sdata, ovf}, 0);
        sclk_pol = 1; sync_pol = 1; rdy_pol = 1;
        #1;
        chk(sclk == 1 && sfs == 1 && rdy == 1, "R1 reset inverted", {sclk, sfs, rdy}, 3'b111);
        sclk_pol = 0; sync_pol = 0; rdy_pol = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(sclk == 0 && sfs == 0 && rdy == 0 && ovf == 0, "R1 after release",
            {sclk, sfs, rdy, ovf}, 0);

        // R2 + R3: every word length, unpacked framing
        for (int c = 0; c < 4; c++) begin
            phase = "R3";
            wsel = 2'(c); pack_mode = 0; div_half = 8'(c % 2);
            s0 = sfs_rises;
            send(32'hA5C3_9E17 ^ (c * 32'h1111_0000), 32'h5A3C_61E8 + c);
            wait_idle();
            chk(sfs_rises - s0 == 2, "R3 two syncs per pair", sfs_rises - s0, 2);
        end

        // R4: packed framing
        phase = "R4";
        wsel = 2'd1; pack_mode = 1; div_half = 8'd2;
        s0 = sfs_rises; r0 = rdy_rises;
        send(32'h0000_8001, 32'h0000_7FFE);
        wait_idle();
        send(32'h0000_F00F, 32'h0000_0FF0);
        wait_idle();
        chk(sfs_rises - s0 == 2, "R4 one sync per pair", sfs_rises - s0, 2);
        chk(rdy_rises - r0 == 2, "R7 one ready edge per pair", rdy_rises - r0, 2);

        // R5/R6/R7: all polarities inverted
        phase = "R5";
        sclk_pol = 1; sync_pol = 1; rdy_pol = 1;
        wsel = 2'd0; pack_mode = 0; div_half = 8'd1;
        send(32'h0000_00B4, 32'h0000_004B);
        wait_idle();
        chk(sclk == 1 && sfs == 1 && rdy == 1, "R6 idle levels inverted", {sclk, sfs, rdy}, 3'b111);
        sclk_pol = 0; sync_pol = 0; rdy_pol = 0;

        // R8: back-to-back with no idle gap
        phase = "R8";
        wsel = 2'd0; pack_mode = 1; div_half = 8'd1;
        r0 = rdy_rises;
        send(32'h0000_00C1, 32'h0000_0037);
        send(32'h0000_0092, 32'h0000_00E6);
        wait_idle();
        chk(rdy_rises - r0 == 2, "R8 both pairs sent", rdy_rises - r0, 2);
        chk(rdy_t1 - rdy_t0 == 2 * 8 * 4, "R8 no gap", rdy_t1 - rdy_t0, 64);
        chk(ovf == 0, "R8 drain-cycle arrival kept", ovf, 0);

        // R10: settings changed mid transfer
        phase = "R10";
        wsel = 2'd2; pack_mode = 0; div_half = 8'd0;
        send(32'h00AB_CDEF, 32'h0012_3456);
        repeat (5) @(negedge clk);
        wsel = 2'd0; pack_mode = 1; div_half = 8'd3;
        wait_idle();
        wsel = 2'd0; pack_mode = 0; div_half = 8'd0;

        // R9: third pair while holding stage full
        phase = "R9";
        r0 = rdy_rises;
        send(32'h0000_0011, 32'h0000_0022);
        send(32'h0000_0033, 32'h0000_0044);
        send(32'h0000_0055, 32'h0000_0066);
        wait_idle();
        chk(rdy_rises - r0 == 2, "R9 dropped pair not sent", rdy_rises - r0, 2);
        chk(ovf == 1, "R9 overflow set", ovf, 1);
        repeat (20) @(negedge clk);
        chk(ovf == 1, "R9 overflow sticky", ovf, 1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R8 watchdog (phase %s) act=timeout exp=finished", phase);
            summary();
            $finish;
        end
    end

endmodule